// File: doc/BRIEF.md
# Accumulator Datapath with Zero and Overflow Flags

This block is the arithmetic core of a small accumulator machine. A single accumulator receives every computed result and every word fetched from data memory. A signed ALU takes its first input from a selector: either the immediate operand or one general-purpose register. Its second input is always the accumulator. The register can only be loaded from the accumulator. Its contents reach the outside world only by running them through the ALU, for example with a pass-through or an AND against all ones.

An external sequencer drives the controls each cycle: function code, source select, accumulator load, register write, memory-read select and memory write. The data-memory side is a plain single-cycle port with no handshake and no back-pressure. Address and write data are presented combinationally, and read data is taken on the same edge that loads the accumulator. Two status outputs follow the accumulator. The zero flag is a live comparison. The overflow bit is captured with each accumulator load.

Top module: `acc_datapath`

## Requirements
- R1: After reset the accumulator, the register and the overflow flag are 0, and the zero flag is 1.
- R2: With `acc_load`=1 and `mem_rd_sel`=0, the accumulator takes the ALU result on the next edge. The `alu_fn` codes are 0 pass input, 1 input+acc, 2 acc−input, 3 AND, 4 OR, 5 XOR, 6 NOT input, 7 input shifted left by one, and 8 input shifted right arithmetically by one.
- R3: `src_sel`=0 feeds `operand` to the ALU's first input, and `src_sel`=1 feeds the general register.
- R4: With `acc_load`=0, the accumulator and the overflow flag keep their values whatever the other controls do.
- R5: With `acc_load`=1 and `mem_rd_sel`=1, the accumulator takes `mem_rdata` on the next edge and the overflow flag is cleared.
- R6: `mem_wdata` always equals the accumulator, `mem_we` equals `mem_wr`, and `mem_addr` equals the low ADDR_W bits of `operand`, all combinationally.
- R7: With `reg_wr`=1, the register takes the accumulator value present before the edge, even when the accumulator loads in the same cycle.
- R8: The overflow flag is set on a load only for signed two's-complement overflow of ADD or SUB. It is 0 after every other function.
- R9: `zero_flag` is 1 exactly while the accumulator equals 0.
- R10: The register value is observable only through the ALU. Pass with `src_sel`=1, or AND with `src_sel`=1 while the accumulator is all ones, returns it unchanged.
- R11: `alu_fn` codes 9 to 15 act as pass-through with overflow 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alu_fn | input | 4 | ALU function code |
| src_sel | input | 1 | ALU first-input select: 0 operand, 1 register |
| acc_load | input | 1 | Load the accumulator this cycle |
| reg_wr | input | 1 | Copy the accumulator into the register |
| mem_rd_sel | input | 1 | Accumulator load source: 0 ALU, 1 memory |
| mem_wr | input | 1 | Request a data-memory write |
| operand | input | DATA_W | Immediate operand, also the address source |
| mem_rdata | input | DATA_W | Data-memory read data |
| mem_addr | output | ADDR_W | Data-memory address |
| mem_wdata | output | DATA_W | Data-memory write data (the accumulator) |
| mem_we | output | 1 | Data-memory write enable |
| acc_out | output | DATA_W | Accumulator value |
| zero_flag | output | 1 | Accumulator equals zero |
| ovf_flag | output | 1 | Signed overflow of the last load |

## Verification
Two actions can share one clock edge, and the bench provokes both. The first is a register write together with an accumulator load. The register must capture the value from before the edge, not the new result. The second is a memory write together with an accumulator load. The write data seen in that cycle must be the accumulator value from before the load. Directed steps set up distinct values on both sides of each edge. A long stretch of random controls then asserts the pairs freely. A behavioural model updates the register from its old accumulator value before it recomputes the accumulator, and every output is compared against that model on every cycle.

// File: rtl/acc_pkg.sv
package acc_pkg;
  typedef enum logic [3:0] {
    FN_PASS = 4'd0,
    FN_ADD  = 4'd1,
    FN_SUB  = 4'd2,
    FN_AND  = 4'd3,
    FN_OR   = 4'd4,
    FN_XOR  = 4'd5,
    FN_NOT  = 4'd6,
    FN_SHL  = 4'd7,
    FN_SRA  = 4'd8
  } alu_fn_e;

  localparam int unsigned FN_W = 4;
endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [FN_W-1:0]   fn,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_acc,
  output logic [DATA_W-1:0] result,
  output logic              ovf
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] diff;
  logic              sum_ovf;
  logic              diff_ovf;

  always_comb begin
    sum      = in_a + in_acc;
    diff     = in_acc - in_a;
    sum_ovf  = (in_a[MSB] == in_acc[MSB]) && (sum[MSB] != in_a[MSB]);
    diff_ovf = (in_acc[MSB] != in_a[MSB]) && (diff[MSB] != in_acc[MSB]);
  end

  always_comb begin
    result = in_a;
    ovf    = 1'b0;
    case (fn)
      FN_ADD: begin
        result = sum;
        ovf    = sum_ovf;
      end
      FN_SUB: begin
        result = diff;
        ovf    = diff_ovf;
      end
      FN_AND:  result = in_a & in_acc;
      FN_OR:   result = in_a | in_acc;
      FN_XOR:  result = in_a ^ in_acc;
      FN_NOT:  result = ~in_a;
      FN_SHL:  result = {in_a[MSB-1:0], 1'b0};
      FN_SRA:  result = {in_a[MSB], in_a[MSB:1]};
      default: result = in_a;
    endcase
  end
endmodule

// File: rtl/acc_src_mux.sv
module acc_src_mux #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              sel,
  input  logic [DATA_W-1:0] imm,
  input  logic [DATA_W-1:0] gpr,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    y = sel ? gpr : imm;
  end
endmodule

// File: rtl/acc_gpr.sv
module acc_gpr #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= d;
  end
endmodule

// File: rtl/acc_core.sv
module acc_core #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              from_mem,
  input  logic [DATA_W-1:0] alu_y,
  input  logic              alu_ovf,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] acc_q,
  output logic              ovf_q,
  output logic              zero
);
  logic [DATA_W-1:0] acc_d;
  logic              ovf_d;

  always_comb begin
    acc_d = from_mem ? rdata : alu_y;
    ovf_d = from_mem ? 1'b0  : alu_ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (load) begin
      acc_q <= acc_d;
      ovf_q <= ovf_d;
    end
  end

  assign zero = (acc_q == '0);
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FN_W-1:0]   alu_fn,
  input  logic              src_sel,
  input  logic              acc_load,
  input  logic              reg_wr,
  input  logic              mem_rd_sel,
  input  logic              mem_wr,
  input  logic [DATA_W-1:0] operand,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [DATA_W-1:0] acc_out,
  output logic              zero_flag,
  output logic              ovf_flag
);
  logic [DATA_W-1:0] reg_q;
  logic [DATA_W-1:0] alu_a;
  logic [DATA_W-1:0] alu_y;
  logic              alu_ovf;

  acc_src_mux #(.DATA_W(DATA_W)) u_mux (
    .sel (src_sel),
    .imm (operand),
    .gpr (reg_q),
    .y   (alu_a)
  );

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .fn     (alu_fn),
    .in_a   (alu_a),
    .in_acc (acc_out),
    .result (alu_y),
    .ovf    (alu_ovf)
  );

  acc_core #(.DATA_W(DATA_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (acc_load),
    .from_mem (mem_rd_sel),
    .alu_y    (alu_y),
    .alu_ovf  (alu_ovf),
    .rdata    (mem_rdata),
    .acc_q    (acc_out),
    .ovf_q    (ovf_flag),
    .zero     (zero_flag)
  );

  acc_gpr #(.DATA_W(DATA_W)) u_gpr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (reg_wr),
    .d     (acc_out),
    .q     (reg_q)
  );

  generate
    if (ADDR_W <= DATA_W) begin : g_addr
      assign mem_addr = operand[ADDR_W-1:0];
    end else begin : g_addr_ext
      assign mem_addr = {{(ADDR_W-DATA_W){1'b0}}, operand};
    end
  endgenerate

  assign mem_wdata = acc_out;
  assign mem_we    = mem_wr;
endmodule

// File: rtl/acc_datapath_chk.sv
module acc_datapath_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        alu_fn,
  input logic              acc_load,
  input logic              reg_wr,
  input logic              mem_rd_sel,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] acc_out,
  input logic [DATA_W-1:0] reg_q,
  input logic              zero_flag,
  input logic              ovf_flag
);
  // R4: no load keeps accumulator and overflow
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_load |=> ($stable(acc_out) && $stable(ovf_flag)));

  // R5: memory load takes read data and clears overflow
  a_r5_mem_load: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_load && mem_rd_sel) |=> (acc_out == $past(mem_rdata) && !ovf_flag));

  // R7: register captures the pre-edge accumulator
  a_r7_reg_capture: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (reg_q == $past(acc_out)));

  // R8: non-arithmetic functions never set overflow
  a_r8_logic_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_load && !mem_rd_sel && (alu_fn == 4'd0 || alu_fn >= 4'd3)) |=> !ovf_flag);

  // R9: zero flag agrees with the memory write data word
  a_r9_zero: assert property (@(posedge clk) disable iff (!rst_n)
    zero_flag == (mem_wdata == '0));
endmodule

bind acc_datapath acc_datapath_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .alu_fn     (alu_fn),
  .acc_load   (acc_load),
  .reg_wr     (reg_wr),
  .mem_rd_sel (mem_rd_sel),
  .mem_rdata  (mem_rdata),
  .mem_wdata  (mem_wdata),
  .acc_out    (acc_out),
  .reg_q      (reg_q),
  .zero_flag  (zero_flag),
  .ovf_flag   (ovf_flag)
);

// File: tb/acc_datapath_tb.sv
module acc_datapath_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] alu_fn = '0;
  logic       src_sel = 1'b0, acc_load = 1'b0, reg_wr = 1'b0;
  logic       mem_rd_sel = 1'b0, mem_wr = 1'b0;
  logic [7:0] operand = '0, mem_rdata = '0;
  logic [7:0] mem_addr, mem_wdata, acc_out;
  logic       mem_we, zero_flag, ovf_flag;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  logic [7:0] acc_m = '0;
  logic [7:0] reg_m = '0;
  logic       ov_m = 1'b0;

  always #4 clk = ~clk;

  acc_datapath u_dut (
    .clk(clk), .rst_n(rst_n), .alu_fn(alu_fn), .src_sel(src_sel),
    .acc_load(acc_load), .reg_wr(reg_wr), .mem_rd_sel(mem_rd_sel),
    .mem_wr(mem_wr), .operand(operand), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .acc_out(acc_out), .zero_flag(zero_flag), .ovf_flag(ovf_flag)
  );

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [3:0] fn, input logic [7:0] a, input logic [7:0] b,
                       output logic [7:0] y, output logic ov);
    int sa, sb, r;
    sa = int'($signed(a));
    sb = int'($signed(b));
    ov = 1'b0;
    r  = sa;
    case (fn)
      4'd1: begin r = sa + sb; ov = (r > 127) || (r < -128); end
      4'd2: begin r = sb - sa; ov = (r > 127) || (r < -128); end
      4'd3: r = int'(a & b);
      4'd4: r = int'(a | b);
      4'd5: r = int'(a ^ b);
      4'd6: r = int'(~a);
      4'd7: r = sa * 2;
      4'd8: r = sa >>> 1;
      default: r = sa;
    endcase
    y = r[7:0];
  endtask

  task automatic step(input logic [3:0] fn, input bit sel, input bit ld, input bit wr,
                      input bit rd, input bit mwr, input logic [7:0] opnd,
                      input logic [7:0] rdat, input string tag);
    logic [7:0] a, y;
    logic ov;
    alu_fn = fn; src_sel = sel; acc_load = ld; reg_wr = wr;
    mem_rd_sel = rd; mem_wr = mwr; operand = opnd; mem_rdata = rdat;
    #1;
    chk(mem_wdata == acc_m, {"R6 wdata ", tag}, mem_wdata, acc_m);
    chk(mem_we == mwr, {"R6 we ", tag}, {7'd0, mem_we}, {7'd0, mwr});
    chk(mem_addr == opnd, {"R6 addr ", tag}, mem_addr, opnd);
    chk(zero_flag == (acc_m == 0), {"R9 zero ", tag}, {7'd0, zero_flag}, {7'd0, acc_m == 0});
    a = sel ? reg_m : opnd;
    model(fn, a, acc_m, y, ov);
    if (wr) reg_m = acc_m;
    if (ld) begin
      if (rd) begin acc_m = rdat; ov_m = 1'b0; end
      else    begin acc_m = y;    ov_m = ov;   end
    end
    @(posedge clk);
    @(negedge clk);
    chk(acc_out == acc_m, {"acc ", tag}, acc_out, acc_m);
    chk(ovf_flag == ov_m, {"ovf ", tag}, {7'd0, ovf_flag}, {7'd0, ov_m});
    chk(zero_flag == (acc_m == 0), {"R9 zero ", tag}, {7'd0, zero_flag}, {7'd0, acc_m == 0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(acc_out == 8'h00, "R1 reset acc", acc_out, 8'h00);
    chk(ovf_flag == 1'b0, "R1 reset ovf", {7'd0, ovf_flag}, 8'h00);
    chk(zero_flag == 1'b1, "R1 reset zero", {7'd0, zero_flag}, 8'h01);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 register reset value seen through pass
    step(4'd0, 1, 1, 0, 0, 0, 8'h55, 8'h00, "R1 R10 reg reset via pass");
    // R2 functions
    step(4'd0, 0, 1, 0, 0, 0, 8'd100, 8'h00, "R2 pass");
    step(4'd1, 0, 1, 0, 0, 0, 8'd20, 8'h00, "R2 add");
    step(4'd1, 0, 1, 0, 0, 0, 8'd100, 8'h00, "R8 add overflow");
    step(4'd0, 0, 1, 0, 0, 0, 8'h80, 8'h00, "R2 pass min");
    step(4'd2, 0, 1, 0, 0, 1, 8'd1, 8'h00, "R8 sub overflow");
    step(4'd2, 0, 1, 0, 0, 0, 8'd127, 8'h00, "R2 sub");
    step(4'd3, 0, 1, 0, 0, 0, 8'hF0, 8'h00, "R2 R8 and");
    step(4'd4, 0, 1, 0, 0, 0, 8'h0F, 8'h00, "R2 or");
    step(4'd5, 0, 1, 0, 0, 0, 8'h3C, 8'h00, "R2 xor");
    step(4'd6, 0, 1, 0, 0, 0, 8'h3C, 8'h00, "R2 not");
    step(4'd7, 0, 1, 0, 0, 0, 8'hC1, 8'h00, "R2 shl");
    step(4'd8, 0, 1, 0, 0, 0, 8'h82, 8'h00, "R2 sra");
    step(4'd11, 0, 1, 0, 0, 0, 8'h6A, 8'h00, "R11 unused code");
    step(4'd1, 0, 1, 0, 0, 0, 8'h96, 8'h00, "R8 add to zero");
    // R7 R10 register through ALU
    step(4'd0, 0, 1, 0, 0, 0, 8'hA7, 8'h00, "R2 setup");
    step(4'd0, 0, 1, 1, 0, 0, 8'h12, 8'h00, "R7 write with load");
    step(4'd0, 1, 1, 0, 0, 0, 8'h00, 8'h00, "R3 R10 pass reg");
    step(4'd0, 0, 1, 0, 0, 0, 8'hFF, 8'h00, "R2 all ones");
    step(4'd3, 1, 1, 0, 0, 0, 8'h00, 8'h00, "R10 and ones");
    // R5 memory load
    step(4'd1, 0, 1, 0, 1, 1, 8'h7F, 8'h5E, "R5 mem read");
    step(4'd1, 0, 1, 0, 0, 0, 8'h7F, 8'h00, "R8 ovf before mem");
    step(4'd1, 0, 1, 0, 1, 0, 8'h7F, 8'h00, "R5 mem clears ovf");
    // R4 hold
    step(4'd1, 0, 1, 0, 0, 0, 8'h70, 8'h00, "R4 setup");
    step(4'd1, 0, 1, 0, 0, 0, 8'h70, 8'h00, "R4 setup ovf");
    step(4'd2, 1, 0, 1, 1, 1, 8'h33, 8'h44, "R4 hold junk");
    step(4'd0, 1, 1, 0, 0, 0, 8'h00, 8'h00, "R4 R7 reg from hold");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[3:0], r[4], r[5] | r[6], r[7], r[8] & r[9], r[10], r[18:11], r[26:19], "R2 R3 R7 random");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule